// File: doc/BRIEF.md
# Partitioned SIMD Vector ALU

This unit executes one vector operation per cycle on two 128-bit source operands. A lane-size input splits the operands into either eight 16-bit lanes or four 32-bit lanes. The same datapath then performs wrapping add and subtract, logical and arithmetic shifts, and bitwise logic on each lane, with no lane affecting its neighbour. It is meant to sit in the execute stage of a media pipeline, where pixel rows and transform coefficients are handled one vector at a time.

Two further operations support pixel work. A compare writes an all-ones or all-zeros mask into each result lane and records the same outcome in a small flag register. A later conditional move reads that flag register to choose each lane from one source or the other. An element-select operation gathers 16-bit elements from the two sources under an index word, so that a pair of selects can turn row-ordered pixels into column order.

The result, the flags and a valid strobe are all registered, so a result appears one cycle after its operation is issued.

Top module: `simd_vec_alu`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release with no operation issued, out_valid, result and cmp_flags are all zero.
- R2: Opcode 0 adds and opcode 1 subtracts (src_a minus src_b). Each lane wraps modulo its width and no carry or borrow crosses a lane boundary. Lane size is 16 bits when wide is 0 and 32 bits when wide is 1.
- R3: Opcode 2 shifts left, opcode 3 shifts right logically and opcode 4 shifts right arithmetically. Every lane uses the same amount: src_b bits [3:0] in 16-bit mode and src_b bits [4:0] in 32-bit mode, which is the amount modulo the lane width. Logical shifts fill with zeros and the arithmetic shift copies each lane's sign bit.
- R4: Opcodes 5, 6 and 7 give the bitwise AND, OR and XOR of the sources.
- R5: Opcode 8 (signed greater-than, src_a above src_b) and opcode 9 (equality) write all ones into each lane where the test holds and all zeros elsewhere. Flag bit i covers 16-bit position i. In 32-bit mode, lane j sets both bits 2j and 2j+1.
- R6: cmp_flags changes only in the cycle after a valid compare. Other operations and idle cycles leave it unchanged.
- R7: Opcode 10 (conditional move) takes each lane from src_b where the flags held at issue mark it, and from src_a otherwise. 16-bit lane i reads flag bit i, and 32-bit lane j reads flag bit 2j.
- R8: Opcode 11 (select) builds 16-bit output element k from the 4-bit index in sel_ctrl bits [4k+3:4k]. Index 0 to 7 picks that element of src_a and index 8 to 15 picks element (index minus 8) of src_b. The wide input has no effect on select.
- R9: out_valid is high exactly one cycle after in_valid, and result then holds the outcome of that operation.
- R10: Opcodes 12 to 15 produce a zero result and leave cmp_flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is issued this cycle |
| opcode | input | 4 | Operation code |
| wide | input | 1 | 0: eight 16-bit lanes, 1: four 32-bit lanes |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector, also holds the shift amount |
| sel_ctrl | input | 32 | Eight 4-bit element indices for select |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 128 | Registered result vector |
| cmp_flags | output | 8 | Registered per-16-bit-position compare flags |

## Verification
The compare and the conditional move interact. A compare updates cmp_flags at the same clock edge that a following conditional move issues against those flags, so a move placed directly behind a compare must see the new flags and not the old ones. The bench issues compare-then-move pairs back to back in both lane sizes and follows them with non-compare operations. Its own model carries the flag state forward in issue order, so each move is judged against the compare just before it, and the flags are checked as unchanged across everything that is not a compare.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SRL  = 4'd3,
    OP_SRA  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CGT  = 4'd8,
    OP_CEQ  = 4'd9,
    OP_CMOV = 4'd10,
    OP_SEL  = 4'd11
  } simd_op_e;

  function automatic logic op_is_compare(input logic [3:0] op);
    return (op == OP_CGT) || (op == OP_CEQ);
  endfunction

  function automatic logic op_is_reserved(input logic [3:0] op);
    return op > OP_SEL;
  endfunction

endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_pkg::*;
#(
  parameter int LW = 16,
  localparam int SHW = $clog2(LW)
) (
  input  logic [3:0]     op,
  input  logic [LW-1:0]  a,
  input  logic [LW-1:0]  b,
  input  logic [SHW-1:0] shamt,
  input  logic           take_b,
  output logic [LW-1:0]  res,
  output logic           gt,
  output logic           eq
);

  function automatic logic [LW-1:0] lane_shift(input logic [LW-1:0] v,
                                               input logic [SHW-1:0] s,
                                               input logic [1:0] kind);
    case (kind)
      2'd0:    return v << s;
      2'd1:    return v >> s;
      default: return LW'($signed(v) >>> s);
    endcase
  endfunction

  assign gt = $signed(a) > $signed(b);
  assign eq = (a == b);

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_SLL:  res = lane_shift(a, shamt, 2'd0);
      OP_SRL:  res = lane_shift(a, shamt, 2'd1);
      OP_SRA:  res = lane_shift(a, shamt, 2'd2);
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CGT:  res = {LW{gt}};
      OP_CEQ:  res = {LW{eq}};
      OP_CMOV: res = take_b ? b : a;
      default: res = '0;
    endcase
  end

  // R5: a lane cannot be both strictly greater and equal
  always_comb begin
    if (!$isunknown({gt, eq})) begin
      a_r5_gt_eq_exclusive: assert (!(gt && eq));
    end
  end

endmodule

// File: rtl/simd_elem_sel.sv
module simd_elem_sel #(
  parameter int EW = 16,
  parameter int NE = 8,
  localparam int IDXW = $clog2(2 * NE)
) (
  input  logic [NE*EW-1:0]   a,
  input  logic [NE*EW-1:0]   b,
  input  logic [NE*IDXW-1:0] ctrl,
  output logic [NE*EW-1:0]   y
);

  logic [EW-1:0] pool [2*NE];

  for (genvar p = 0; p < NE; p++) begin : g_pool
    assign pool[p]      = a[p*EW +: EW];
    assign pool[p + NE] = b[p*EW +: EW];
  end

  for (genvar k = 0; k < NE; k++) begin : g_out
    logic [IDXW-1:0] idx;
    assign idx = ctrl[k*IDXW +: IDXW];
    assign y[k*EW +: EW] = pool[idx];
  end

endmodule

// File: rtl/simd_vec_alu.sv
module simd_vec_alu
  import simd_pkg::*;
#(
  parameter int VW = 128,
  parameter int EW = 16,
  localparam int NN    = VW / EW,
  localparam int NW    = VW / (2 * EW),
  localparam int IDXW  = $clog2(2 * NN),
  localparam int CTRLW = NN * IDXW,
  localparam int SHN   = $clog2(EW),
  localparam int SHW   = $clog2(2 * EW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       opcode,
  input  logic             wide,
  input  logic [VW-1:0]    src_a,
  input  logic [VW-1:0]    src_b,
  input  logic [CTRLW-1:0] sel_ctrl,
  output logic             out_valid,
  output logic [VW-1:0]    result,
  output logic [NN-1:0]    cmp_flags
);

  logic [VW-1:0] res_n, res_w, sel_y, nxt_res;
  logic [NN-1:0] gt_n, eq_n, nxt_flags;
  logic [NW-1:0] gt_w, eq_w;
  logic          is_cmp, is_rsv;

  assign is_cmp = op_is_compare(opcode);
  assign is_rsv = op_is_reserved(opcode);

  for (genvar i = 0; i < NN; i++) begin : g_narrow
    simd_lane_op #(.LW(EW)) u_lane (
      .op    (opcode),
      .a     (src_a[i*EW +: EW]),
      .b     (src_b[i*EW +: EW]),
      .shamt (src_b[SHN-1:0]),
      .take_b(cmp_flags[i]),
      .res   (res_n[i*EW +: EW]),
      .gt    (gt_n[i]),
      .eq    (eq_n[i])
    );
  end

  for (genvar j = 0; j < NW; j++) begin : g_wide
    simd_lane_op #(.LW(2*EW)) u_lane (
      .op    (opcode),
      .a     (src_a[j*2*EW +: 2*EW]),
      .b     (src_b[j*2*EW +: 2*EW]),
      .shamt (src_b[SHW-1:0]),
      .take_b(cmp_flags[2*j]),
      .res   (res_w[j*2*EW +: 2*EW]),
      .gt    (gt_w[j]),
      .eq    (eq_w[j])
    );
  end

  simd_elem_sel #(.EW(EW), .NE(NN)) u_sel (
    .a   (src_a),
    .b   (src_b),
    .ctrl(sel_ctrl),
    .y   (sel_y)
  );

  always_comb begin
    if (opcode == OP_SEL) nxt_res = sel_y;
    else if (wide)        nxt_res = res_w;
    else                  nxt_res = res_n;
  end

  always_comb begin
    for (int i = 0; i < NN; i++) begin
      if (wide) nxt_flags[i] = (opcode == OP_CGT) ? gt_w[i/2] : eq_w[i/2];
      else      nxt_flags[i] = (opcode == OP_CGT) ? gt_n[i]   : eq_n[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cmp_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt_res;
      if (in_valid && is_cmp) cmp_flags <= nxt_flags;
    end
  end

  // Observation wires for the assertions
  logic [NN-1:0] mask_match;
  logic [NW-1:0] pair_match;
  for (genvar i = 0; i < NN; i++) begin : g_mm
    assign mask_match[i] = (result[i*EW +: EW] == {EW{cmp_flags[i]}});
  end
  for (genvar j = 0; j < NW; j++) begin : g_pm
    assign pair_match[j] = (cmp_flags[2*j] == cmp_flags[2*j+1]);
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && is_cmp) |=> $stable(cmp_flags));
  a_r5_mask_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp) |=> &mask_match);
  a_r5_wide_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp && wide) |=> &pair_match);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_rsv) |=> (result == '0));

endmodule

// File: tb/simd_vec_alu_test.sv
module simd_vec_alu_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   opcode = '0;
  logic         wide = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [31:0]  sel_ctrl = '0;
  logic         out_valid;
  logic [127:0] result;
  logic [7:0]   cmp_flags;

  simd_vec_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .wide(wide), .src_a(src_a), .src_b(src_b), .sel_ctrl(sel_ctrl),
    .out_valid(out_valid), .result(result), .cmp_flags(cmp_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [127:0] res;
    logic [7:0]   flg;
    string        tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  int          popped = 0;
  int          pushed = 0;
  logic [7:0]  m_flags = '0;

  function automatic void ref_op(input logic [3:0] op, input logic w,
                                 input logic [127:0] a, input logic [127:0] b,
                                 input logic [31:0] ctl, input logic [7:0] fin,
                                 output logic [127:0] r, output logic [7:0] fo);
    int lw, n, sh;
    logic [31:0] lm, x, y, sx, sy, v;
    logic m, take;
    lw = w ? 32 : 16;
    n  = 128 / lw;
    lm = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    sh = w ? int'(b[4:0]) : int'(b[3:0]);
    fo = fin;
    r  = '0;
    if (op == 4'd11) begin
      for (int k = 0; k < 8; k++) begin
        int idx;
        idx = int'(ctl[4*k +: 4]);
        r[16*k +: 16] = (idx < 8) ? a[16*idx +: 16] : b[16*(idx-8) +: 16];
      end
      return;
    end
    if (op >= 4'd12) return;
    for (int j = 0; j < n; j++) begin
      x  = 32'(a >> (j*lw)) & lm;
      y  = 32'(b >> (j*lw)) & lm;
      sx = w ? x : {{16{x[15]}}, x[15:0]};
      sy = w ? y : {{16{y[15]}}, y[15:0]};
      take = w ? fin[2*j] : fin[j];
      m = 1'b0;
      case (op)
        4'd0: v = x + y;
        4'd1: v = x - y;
        4'd2: v = x << sh;
        4'd3: v = x >> sh;
        4'd4: v = 32'($signed(sx) >>> sh);
        4'd5: v = x & y;
        4'd6: v = x | y;
        4'd7: v = x ^ y;
        4'd8: begin m = $signed(sx) > $signed(sy); v = m ? lm : 32'd0; end
        4'd9: begin m = (x == y); v = m ? lm : 32'd0; end
        default: v = take ? y : x;
      endcase
      r = r | (128'(v & lm) << (j*lw));
      if (op == 4'd8 || op == 4'd9) begin
        if (w) begin fo[2*j] = m; fo[2*j+1] = m; end
        else fo[j] = m;
      end
    end
  endfunction

  task automatic issue(input logic [3:0] op, input logic w,
                       input logic [127:0] a, input logic [127:0] b,
                       input logic [31:0] ctl, input string tag);
    exp_t e;
    @(negedge clk);
    opcode = op; wide = w; src_a = a; src_b = b; sel_ctrl = ctl;
    in_valid = 1'b1;
    ref_op(op, w, a, b, ctl, m_flags, e.res, e.flg);
    m_flags = e.flg;
    e.tag = tag;
    sb.push_back(e);
    pushed++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = '1; src_b = '1; opcode = 4'd8;
    end
  endtask

  // Monitor: pops the scoreboard as results emerge
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R9: out_valid with no pending op (actual=1 expected=0)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        popped++;
        if (result !== e.res || cmp_flags !== e.flg) begin
          bad++;
          $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                   e.tag, result, cmp_flags, e.res, e.flg);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: run hung (actual=timeout expected=done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] ra, rb;
    // R1: reset state
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== '0 || cmp_flags !== '0) begin
      bad++;
      $display("FAIL R1: valid=%b result=%h flags=%b expected 0/0/0",
               out_valid, result, cmp_flags);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== '0 || cmp_flags !== '0) begin
      bad++;
      $display("FAIL R1: after release valid=%b result=%h flags=%b expected 0/0/0",
               out_valid, result, cmp_flags);
    end

    // R2: wrap per lane, both sizes
    issue(4'd0, 1'b0, 128'h0001_7FFF_0000_FFFF_1234_FFFF_8000_FFFF,
                      128'h0001_0001_0000_0001_1111_0002_8000_0001, '0, "R2 add16");
    issue(4'd0, 1'b1, 128'hFFFF_FFFF_0000_FFFF_7FFF_FFFF_1234_5678,
                      128'h0000_0001_0000_0001_0000_0001_1111_1111, '0, "R2 add32");
    issue(4'd1, 1'b0, 128'h0000_0005_0000_0000_8000_0001_FFFF_0000,
                      128'h0001_0003_0000_0001_0001_0002_FFFF_0001, '0, "R2 sub16");
    issue(4'd1, 1'b1, 128'h0000_0000_0001_0000_8000_0000_0000_0005,
                      128'h0000_0001_0000_0001_0000_0001_0000_0007, '0, "R2 sub32");
    idle(1);

    // R3: shifts, amount modulo lane width
    ra = 128'h8001_7FFF_F0F0_0001_8000_1234_FFFF_4321;
    issue(4'd2, 1'b0, ra, 128'h0000_0000_0000_0000_0000_0000_0000_0004, '0, "R3 sll16");
    issue(4'd3, 1'b0, ra, 128'h0000_0000_0000_0000_0000_0000_0000_000F, '0, "R3 srl16");
    issue(4'd4, 1'b0, ra, 128'h0000_0000_0000_0000_0000_0000_0000_0014, '0, "R3 sra16 mod");
    issue(4'd4, 1'b1, ra, 128'h0000_0000_0000_0000_0000_0000_0000_0011, '0, "R3 sra32");
    issue(4'd3, 1'b1, ra, 128'h0000_0000_0000_0000_0000_0000_0000_0025, '0, "R3 srl32 mod");
    issue(4'd2, 1'b1, ra, '0, '0, "R3 sll32 zero");

    // R4: logic
    ra = 128'hF0F0_F0F0_AAAA_5555_1234_5678_9ABC_DEF0;
    rb = 128'hFF00_00FF_5555_5555_0F0F_0F0F_FFFF_0000;
    issue(4'd5, 1'b0, ra, rb, '0, "R4 and");
    issue(4'd6, 1'b1, ra, rb, '0, "R4 or");
    issue(4'd7, 1'b0, ra, rb, '0, "R4 xor");
    idle(2);

    // R5, R7: compare then conditional move back to back
    ra = 128'h0005_FFFF_7FFF_8000_0003_0000_1234_0001;
    rb = 128'h0005_0001_8000_7FFF_0002_0000_1235_FFFF;
    issue(4'd8, 1'b0, ra, rb, '0, "R5 cgt16");
    issue(4'd10, 1'b0, ra, rb, '0, "R7 cmov16");
    issue(4'd9, 1'b0, ra, rb, '0, "R5 ceq16");
    issue(4'd10, 1'b0, ra, rb, '0, "R7 cmov16 eq");
    issue(4'd9, 1'b1, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
                      128'h1111_2222_3333_4445_5555_6666_0000_8888, '0, "R5 ceq32");
    issue(4'd10, 1'b1, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
                       128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000_1111, '0, "R7 cmov32");
    issue(4'd8, 1'b1, 128'h8000_0000_0000_0001_FFFF_FFFF_7FFF_FFFF,
                      128'h7FFF_FFFF_0000_0000_0000_0000_8000_0000, '0, "R5 cgt32");
    // R6: non-compare ops and idle cycles leave flags
    issue(4'd0, 1'b0, '1, '1, '0, "R6 add keeps flags");
    idle(3);
    issue(4'd10, 1'b0, '0, '1, '0, "R6 R7 flags after idle");

    // R8: select, lane size ignored; two selects transpose a 2x2 of pairs
    ra = 128'h0007_0006_0005_0004_0003_0002_0001_0000;
    rb = 128'h000F_000E_000D_000C_000B_000A_0009_0008;
    issue(4'd11, 1'b0, ra, rb, 32'hB3A2_9180, "R8 interleave low");
    issue(4'd11, 1'b1, ra, rb, 32'hF7E6_D5C4, "R8 interleave high wide");
    issue(4'd11, 1'b0, ra, rb, 32'h0F1E_2D3C, "R8 mixed");

    // R10: reserved opcodes
    issue(4'd12, 1'b0, '1, '1, '1, "R10 op12");
    issue(4'd15, 1'b1, '1, '1, '1, "R10 op15");
    idle(1);

    // R9 and all ops: random mix with back-to-back and gaps
    for (int t = 0; t < 80; t++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (t % 5 == 0) rb[15:0] = ra[15:0];
      issue(4'($urandom_range(0, 15)), 1'($urandom), ra, rb, $urandom, "R9 random");
      if (t % 7 == 3) idle(1);
    end
    idle(3);

    total++;
    if (popped != pushed || sb.size() != 0) begin
      bad++;
      $display("FAIL R9: results seen=%0d expected=%0d", popped, pushed);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule